// File: doc/BRIEF.md
# Prioritised Interrupt Aggregator

This block merges the interrupt requests of six peripherals into one host interrupt line. The peripherals are two I2C masters, an SPI controller, two DMA channels and a common-interface controller. Each request is captured into a per-source status bit. A mask register decides which captured bits may reach the host. The mask is never written directly: one address sets the mask bits written as one, and another address clears them.

A global enable bit gates the merged line. A separate global status register reports whether any unmasked source is pending, whatever the state of the enable. This lets a service routine drop the line, look for a pending source, and raise the line again. A priority index register names the most urgent pending source in a fixed order, so software needs only one read to find the source to service.

The block is reached through a simple word register port. Reads are combinational from the address. Writes take effect at the clock edge on which `reg_wr` is high. A parameter selects whether requests are captured as levels (status follows the request) or as rising edges (status stays set until software clears it).

Top module: `irq_funnel`

## Requirements
- R1: After reset the status, the mask and the global enable are all zero, `host_irq` is low, and the priority index reads 0xF.
- R2: In level mode, status bit i equals `irq_req[i]` as sampled at the previous clock edge. It is read at address 0, with bit i for source i and the upper bits zero. Writes to address 0 have no effect in level mode.
- R3: A write to address 2 sets every mask bit whose data bit is one and leaves the other mask bits unchanged. The mask reads back at address 1, with bit i for source i.
- R4: A write to address 3 clears every mask bit whose data bit is one. Writing 0xFFFF there clears the whole mask.
- R5: Address 4 holds the global enable in bit 7. A write stores data bit 7 and ignores the other bits. A read returns 0x0080 when enabled and 0x0000 otherwise. Writing 0 drops `host_irq` from the next cycle on.
- R6: `host_irq` is high exactly when the global enable is set and at least one source has both its status bit and its mask bit set. It reflects register updates made at the preceding clock edge.
- R7: Address 5 reads 0x0080 when any source has both its status bit and its mask bit set, independently of the global enable, and 0x0000 otherwise.
- R8: Address 6 returns the index of the pending unmasked source that ranks first in the order 0 (I2C master 0), 1 (I2C master 1), 2 (SPI), 3 (DMA channel 1), 4 (DMA channel 2), 5 (common-interface controller). It returns 0xF when no unmasked source is pending.
- R9: When the global enable is written from 0 to 1 while an unmasked source is still pending, `host_irq` is high in the cycle after the write.
- R10: In edge mode (`CAPTURE_EDGE`=1), a rising edge of `irq_req[i]` sets status bit i, and the bit stays set after the request falls. Writing one to bit i of address 0 clears it. If a rising edge and the clear arrive in the same cycle, the bit is set.
- R11: Addresses 2, 3 and 7 read as zero. A write to address 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Peripheral requests, bit i for source i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr`, combinational |
| host_irq | output | 1 | Merged interrupt line to the host |

## Verification
Every state element updates on one clock edge. A request or a write applied before edge k is therefore visible on `host_irq`, on the status, global status and priority reads, and on the mask and enable reads right after edge k. Read data follows the address with no clock at all. The bench drives inputs at the falling edge and lets the design take them at the next rising edge. At the following falling edge it compares `host_irq`, then steps the read address and compares `reg_rdata` within that half cycle, against a model advanced once per rising edge. A level-mode and an edge-mode instance share the register port, so every write is checked in both capture variants.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;
   localparam int REG_ADDR_W = 3;

   localparam logic [REG_ADDR_W-1:0] A_STATUS   = 3'd0;
   localparam logic [REG_ADDR_W-1:0] A_MASK     = 3'd1;
   localparam logic [REG_ADDR_W-1:0] A_MASK_SET = 3'd2;
   localparam logic [REG_ADDR_W-1:0] A_MASK_CLR = 3'd3;
   localparam logic [REG_ADDR_W-1:0] A_GEN      = 3'd4;
   localparam logic [REG_ADDR_W-1:0] A_GSTAT    = 3'd5;
   localparam logic [REG_ADDR_W-1:0] A_PRIO     = 3'd6;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
   parameter int N_SRC        = 6,
   parameter bit CAPTURE_EDGE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req,
   input  logic [N_SRC-1:0] clr,
   output logic [N_SRC-1:0] status
);
   if (CAPTURE_EDGE) begin : g_edge
      logic [N_SRC-1:0] req_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q  <= '0;
            status <= '0;
         end else begin
            req_q  <= req;
            status <= (status & ~clr) | (req & ~req_q);
         end
      end

      for (genvar i = 0; i < N_SRC; i++) begin : g_chk
         // R10: a rising edge is caught, and a set bit holds until cleared
         p_edge_catch_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !req_q[i]) |=> status[i]);
         p_edge_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]);
      end
   end else begin : g_level
      logic unused_clr;
      assign unused_clr = ^clr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status <= '0;
         else        status <= req;
      end

      // R2: level capture follows the request one cycle late
      p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (status == $past(req)));
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int N_SRC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_bits,
   input  logic [N_SRC-1:0] clr_bits,
   output logic [N_SRC-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= (mask | set_bits) & ~clr_bits;
   end

   // R3: set write raises the chosen bits
   p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0 && clr_bits == '0) |=> ((mask & $past(set_bits)) == $past(set_bits)));
   // R4: clear write drops the chosen bits
   p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits != '0) |=> ((mask & $past(clr_bits)) == '0));
   // R3: no set or clear leaves the mask alone
   p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits == '0 && clr_bits == '0) |=> $stable(mask));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N_SRC = 6,
   parameter int IDX_W = 4
) (
   input  logic [N_SRC-1:0] active,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] IDX_NONE = '1;

   always_comb begin
      idx = IDX_NONE;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (active[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
   import irq_funnel_pkg::*;
#(
   parameter int N_SRC        = 6,
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = REG_ADDR_W,
   parameter int GEN_BIT      = 7,
   parameter int IDX_W        = 4,
   parameter bit CAPTURE_EDGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_req,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              host_irq
);
   localparam logic [IDX_W-1:0] IDX_NONE = '1;

   if (N_SRC < 1 || N_SRC >= (1 << IDX_W) - 1 + 1 || N_SRC > DATA_W) begin : g_bad_nsrc
      $error("irq_funnel: N_SRC must be 1..2**IDX_W-1 and fit in DATA_W");
   end
   if (GEN_BIT >= DATA_W) begin : g_bad_gen
      $error("irq_funnel: GEN_BIT must lie inside DATA_W");
   end
   if (ADDR_W != REG_ADDR_W) begin : g_bad_addr
      $error("irq_funnel: ADDR_W must match the register map");
   end

   logic             unused_wdata;
   logic             gen_en;
   logic [N_SRC-1:0] status;
   logic [N_SRC-1:0] mask;
   logic [N_SRC-1:0] active;
   logic [N_SRC-1:0] set_bits, clr_bits, st_clr;
   logic [IDX_W-1:0] prio_idx;
   logic             any_active;
   logic [N_SRC-1:0] pend_next;

   assign unused_wdata = ^reg_wdata;

   assign set_bits = (reg_wr && reg_addr == A_MASK_SET) ? reg_wdata[N_SRC-1:0] : '0;
   assign clr_bits = (reg_wr && reg_addr == A_MASK_CLR) ? reg_wdata[N_SRC-1:0] : '0;
   assign st_clr   = (reg_wr && reg_addr == A_STATUS)   ? reg_wdata[N_SRC-1:0] : '0;

   irq_capture #(.N_SRC(N_SRC), .CAPTURE_EDGE(CAPTURE_EDGE)) u_capture (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(st_clr), .status(status)
   );

   irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits), .mask(mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gen_en <= 1'b0;
      else if (reg_wr && reg_addr == A_GEN) gen_en <= reg_wdata[GEN_BIT];
   end

   assign active     = status & mask;
   assign any_active = |active;
   assign host_irq   = gen_en & any_active;

   irq_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
      .active(active), .idx(prio_idx)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_STATUS: reg_rdata[N_SRC-1:0] = status;
         A_MASK:   reg_rdata[N_SRC-1:0] = mask;
         A_GEN:    reg_rdata[GEN_BIT]   = gen_en;
         A_GSTAT:  reg_rdata[GEN_BIT]   = any_active;
         A_PRIO:   reg_rdata[IDX_W-1:0] = prio_idx;
         default:  reg_rdata = '0;
      endcase
   end

   // sources that will still be pending after the next edge if no clear hits them
   if (CAPTURE_EDGE) begin : g_pend_edge
      assign pend_next = status;
   end else begin : g_pend_level
      assign pend_next = irq_req;
   end

   // R5: writing a zero enable drops the line on the next cycle
   p_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_GEN && !reg_wdata[GEN_BIT]) |=> !host_irq);
   // R9: re-enabling with a pending unmasked source raises the line next cycle
   p_reenable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_GEN && reg_wdata[GEN_BIT] && (|(pend_next & mask)))
      |=> host_irq);
   // R8: the index names a pending source with nothing more urgent below it
   p_prio_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_idx != IDX_NONE) |->
         (((active >> prio_idx) & N_SRC'(1)) != '0) &&
         ((active & ((N_SRC'(1) << prio_idx) - N_SRC'(1))) == '0));
   p_prio_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_idx == IDX_NONE) |-> (active == '0));
endmodule

// File: tb/irq_funnel_tb.sv
`timescale 1ns/1ps
module irq_funnel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [5:0]  req_l = '0, req_e = '0;
   logic [15:0] rd_l, rd_e;
   logic        irq_l, irq_e;

   int unsigned n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   logic [5:0] m_mask, m_stl, m_ste, m_reqq;
   logic       m_en;

   always #2.5 clk = ~clk;

   irq_funnel #(.CAPTURE_EDGE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(req_l), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rd_l), .host_irq(irq_l)
   );
   irq_funnel #(.CAPTURE_EDGE(1'b1)) u_dut_edge (
      .clk(clk), .rst_n(rst_n), .irq_req(req_e), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rd_e), .host_irq(irq_e)
   );

   function automatic logic [15:0] prio_of(input logic [5:0] act);
      logic [15:0] p;
      p = 16'h000F;
      for (int i = 5; i >= 0; i--) if (act[i]) p = 16'(i);
      return p;
   endfunction

   function automatic logic [15:0] exp_rd(input logic [2:0] a, input logic [5:0] st);
      case (a)
         3'd0: return {10'b0, st};
         3'd1: return {10'b0, m_mask};
         3'd4: return m_en ? 16'h0080 : 16'h0000;
         3'd5: return (|(st & m_mask)) ? 16'h0080 : 16'h0000;
         3'd6: return prio_of(st & m_mask);
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a, input bit edge_mode);
      case (a)
         3'd0: return edge_mode ? "R10" : "R2";
         3'd1: return "R3";
         3'd4: return "R5";
         3'd5: return "R7";
         3'd6: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: inputs applied at the falling edge, model advanced at the rising edge
   task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d,
                      input logic [5:0] rl, input logic [5:0] re, input string tag = "R6");
      logic [5:0] clr;
      wr = w; addr = a; wdata = d; req_l = rl; req_e = re;
      @(posedge clk);
      clr = (w && a == 3'd0) ? d[5:0] : 6'd0;
      m_stl = rl;
      m_ste = (m_ste & ~clr) | (re & ~m_reqq);
      m_reqq = re;
      if (w && a == 3'd2) m_mask = m_mask | d[5:0];
      if (w && a == 3'd3) m_mask = m_mask & ~d[5:0];
      if (w && a == 3'd4) m_en = d[7];
      @(negedge clk);
      wr = 1'b0;
      chk(tag, {15'b0, irq_l}, {15'b0, m_en & (|(m_stl & m_mask))});
      chk(tag, {15'b0, irq_e}, {15'b0, m_en & (|(m_ste & m_mask))});
   endtask

   task automatic rd(input logic [2:0] a);
      addr = a;
      #0.2;
      chk(tag_of(a, 1'b0), rd_l, exp_rd(a, m_stl));
      chk(tag_of(a, 1'b1), rd_e, exp_rd(a, m_ste));
   endtask

   task automatic rd_all();
      for (int a = 0; a < 8; a++) rd(3'(a));
   endtask

   initial begin
      m_mask = '0; m_stl = '0; m_ste = '0; m_reqq = '0; m_en = 1'b0;
      void'($urandom(32'h1A2B3C4D));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", {15'b0, irq_l}, 16'h0);
      chk("R1", {15'b0, irq_e}, 16'h0);
      rd_all();
      chk("R1", rd_l, 16'h0);
      rd(3'd6);
      chk("R1", rd_l, 16'h000F);

      // R3: set with upper data bits, then partial sets keep prior bits
      cyc(1, 3'd2, 16'hFF05, 6'd0, 6'd0); rd(3'd1);
      chk("R3", rd_l, 16'h0005);
      cyc(1, 3'd2, 16'h0020, 6'd0, 6'd0); rd(3'd1);
      chk("R3", rd_l, 16'h0025);
      // R4: clear all
      cyc(1, 3'd3, 16'hFFFF, 6'd0, 6'd0); rd(3'd1);
      chk("R4", rd_l, 16'h0000);

      // R8: priority order
      cyc(1, 3'd2, 16'h003F, 6'd0, 6'd0);
      cyc(1, 3'd4, 16'h0080, 6'b101000, 6'b101000); rd(3'd6);
      chk("R8", rd_l, 16'h0003);
      cyc(0, 3'd0, 16'h0, 6'b110000, 6'b0); rd(3'd6);
      chk("R8", rd_l, 16'h0004);
      cyc(0, 3'd0, 16'h0, 6'b100000, 6'b0); rd(3'd6);
      chk("R8", rd_l, 16'h0005);
      cyc(0, 3'd0, 16'h0, 6'b111111, 6'b0); rd_all();

      // R2: status write ignored in level mode
      cyc(1, 3'd0, 16'hFFFF, 6'b010010, 6'b0, "R2"); rd(3'd0);
      chk("R2", rd_l, 16'h0012);

      // masked-out source: no line, no status, index 0xF
      cyc(1, 3'd3, 16'h0012, 6'b010010, 6'b0); rd_all();
      chk("R7", rd_l, 16'h0000);
      chk("R6", {15'b0, irq_l}, 16'h0);

      // R5 / R7 / R9: disable with pending, global status still set, re-enable
      cyc(1, 3'd2, 16'h0002, 6'b010010, 6'b0);
      cyc(1, 3'd4, 16'h007F, 6'b010010, 6'b0, "R5"); rd(3'd4);
      chk("R5", rd_l, 16'h0000);
      chk("R5", {15'b0, irq_l}, 16'h0);
      rd(3'd5);
      chk("R7", rd_l, 16'h0080);
      cyc(1, 3'd4, 16'h0080, 6'b010010, 6'b0, "R9");
      chk("R9", {15'b0, irq_l}, 16'h1);

      // R10: edge capture stays set, clears on write, edge beats clear
      cyc(0, 3'd0, 16'h0, 6'b0, 6'b000100, "R10");
      cyc(0, 3'd0, 16'h0, 6'b0, 6'b000000, "R10"); rd(3'd0);
      chk("R10", rd_e, 16'h0004);
      cyc(1, 3'd0, 16'h0004, 6'b0, 6'b0, "R10"); rd(3'd0);
      chk("R10", rd_e, 16'h0000);
      cyc(1, 3'd0, 16'h0008, 6'b0, 6'b001000, "R10"); rd(3'd0);
      chk("R10", rd_e, 16'h0008);

      // R11: unmapped write changes nothing
      cyc(1, 3'd7, 16'hFFFF, 6'b0, 6'b0, "R11"); rd_all();
      chk("R11", rd_l, 16'h0000);

      // randomised mix
      for (int k = 0; k < 3000; k++) begin
         logic [2:0] a;
         a = 3'($urandom % 8);
         cyc(1'($urandom % 2), a, 16'($urandom), 6'($urandom), 6'($urandom % 4 == 0 ? $urandom : 0));
         rd(3'($urandom % 8));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule